// File: doc/BRIEF.md
# Debug State Save/Restore Port

This block lets software stream a small set of debug state out of the chip before a power-down, and stream it back in after power-up. All of the state passes through a single 32-bit data register whose internal pointer moves forward on each access. Save and restore use the same word order.

The port only works while a keyed lock is held. After the lock is set, the first read of the data register returns the number of state words. Each later read returns the next state word. Restore works the same way: the first write stands for the count, and each later write loads the next word. A restore replaces the live transfer registers and status flags, so whatever they held before is lost. When the lock is released and catch-on-unlock is enabled, the block raises a one-cycle debug event.

The stand-in state is:
- a transmit data register;
- a receive data register;
- four status flags;
- a catch-on-unlock enable bit.

Software can also read and write each of these directly at its own address.

Top module: `dbg_state_port`

## Requirements
- R1: After reset the lock is clear, the transmit register, receive register, flags and catch enable are zero, event_o is low, and the sequence pointer is at the count step.
- R2: A write of 0xC5ACCE55 to byte address 0x300 sets the lock. Reading 0x300 returns the lock state in bit 0.
- R3: A write of any other value to 0x300 clears the lock.
- R4: While the lock is set, the first access to the data register at 0x308 reads NUM_WORDS.
- R5: Later reads of 0x308 return the state words in this order:
  - transmit register;
  - receive register;
  - flags word;
  - catch word;
  - zero for every padding word, up to NUM_WORDS.
- R6: Restore mirrors save. The first write to 0x308 under lock is consumed as the count. Each later write loads the next word in the R5 order, replacing the live value. The flags word holds tx_full in bit 3, tx_full_l in bit 2, rx_full in bit 1 and rx_full_l in bit 0. The catch word holds the enable in bit 0.
- R7: Any write to 0x300 returns the sequence pointer to the count step.
- R8: When a write to 0x300 takes the lock from set to clear while catch enable is 1, event_o is high for exactly the next cycle. In every other case event_o stays low.
- R9: While the lock is clear, accesses to 0x308 read zero and change no state or pointer.
- R10: Accesses to 0x308 after the last state word read zero and change nothing.
- R11: Direct registers, all read/write:
  - transmit register at 0x080;
  - receive register at 0x084;
  - flags at 0x088, bits [3:0];
  - catch enable at 0x0A0, bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe; advances the sequence on a data-port read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from address and state |
| event_o | output | 1 | One-cycle debug event on unlock |

## Verification
The data port is exercised with three directed patterns:
- a full save sequence, which checks the word order;
- a full restore of distinct values over live contents, which shows the old contents are discarded;
- overrun past the last word, which shows the pointer saturates.

Seeded random interleavings add key writes, wrong-key writes, direct register writes and data-port accesses. These show that lock writes rewind the pointer at any step. They also show that unlocked accesses do nothing. Unlock events are checked with catch enabled and disabled, and with the lock already clear, to separate a real lock release from a plain write to the lock register.

// File: rtl/dbg_state_pkg.sv
package dbg_state_pkg;
  localparam logic [31:0] LOCK_KEY   = 32'hC5AC_CE55;
  localparam int unsigned OFF_LOCK   = 'h300;
  localparam int unsigned OFF_SSR    = 'h308;
  localparam int unsigned OFF_TX     = 'h080;
  localparam int unsigned OFF_RX     = 'h084;
  localparam int unsigned OFF_FLAGS  = 'h088;
  localparam int unsigned OFF_CATCH  = 'h0A0;
  localparam int unsigned CORE_WORDS = 4;

  typedef struct packed {
    logic tx_full;
    logic tx_full_l;
    logic rx_full;
    logic rx_full_l;
  } dcc_flags_t;
endpackage

// File: rtl/dbg_lock_ctrl.sv
module dbg_lock_ctrl
  import dbg_state_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        lock_wr_i,
  input  logic [31:0] wdata_i,
  input  logic        catch_en_i,
  output logic        locked_o,
  output logic        event_o
);
  logic locked_q, event_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      event_q  <= 1'b0;
    end else begin
      event_q <= lock_wr_i && locked_q && (wdata_i != LOCK_KEY) && catch_en_i;
      if (lock_wr_i) locked_q <= (wdata_i == LOCK_KEY);
    end
  end

  assign locked_o = locked_q;
  assign event_o  = event_q;

  a_r2_key_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_wr_i && wdata_i == LOCK_KEY) |=> locked_q);
  a_r3_other_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_wr_i && wdata_i != LOCK_KEY) |=> !locked_q);
  a_r8_event_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_q |=> !event_q);
  a_r8_event_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_q |-> ($fell(locked_q) && $past(catch_en_i)));
endmodule

// File: rtl/dbg_seq_ptr.sv
module dbg_seq_ptr #(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned PTR_W     = $clog2(NUM_WORDS + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_wr_i,
  input  logic             ssr_acc_i,
  input  logic             locked_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_WORDS);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   ptr_q <= '0;
    else if (lock_wr_i)                            ptr_q <= '0;
    else if (ssr_acc_i && locked_i && ptr_q <= LAST) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  a_r7_ptr_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_wr_i |=> (ptr_q == '0));
  a_r9_unlocked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_i && !lock_wr_i) |=> $stable(ptr_q));
  a_r10_ptr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST + 1'b1);
endmodule

// File: rtl/dbg_state_regs.sv
module dbg_state_regs
  import dbg_state_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_we_i,
  input  logic        rx_we_i,
  input  logic        flags_we_i,
  input  logic        catch_we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] tx_o,
  output logic [31:0] rx_o,
  output dcc_flags_t  flags_o,
  output logic        catch_o
);
  logic [31:0] tx_q, rx_q;
  dcc_flags_t  flags_q;
  logic        catch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q    <= '0;
      rx_q    <= '0;
      flags_q <= '0;
      catch_q <= 1'b0;
    end else begin
      if (tx_we_i)    tx_q    <= wdata_i;
      if (rx_we_i)    rx_q    <= wdata_i;
      if (flags_we_i) flags_q <= dcc_flags_t'(wdata_i[3:0]);
      if (catch_we_i) catch_q <= wdata_i[0];
    end
  end

  assign tx_o    = tx_q;
  assign rx_o    = rx_q;
  assign flags_o = flags_q;
  assign catch_o = catch_q;

  a_r6_tx_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_we_i |=> (tx_q == $past(wdata_i)));
  a_r6_flags_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_we_i |=> (flags_q == $past(wdata_i[3:0])));
  a_r9_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_we_i |=> $stable(tx_q));
endmodule

// File: rtl/dbg_state_port.sv
module dbg_state_port
  import dbg_state_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_WORDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              event_o
);
  localparam int unsigned PTR_W = $clog2(NUM_WORDS + 2);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_WORDS);

  logic sel_lock, sel_ssr, sel_tx, sel_rx, sel_flags, sel_catch;
  logic locked, lock_wr, ssr_acc, ssr_live;
  logic [PTR_W-1:0] ptr;
  logic [31:0] tx, rx;
  dcc_flags_t  flags;
  logic        catch_en;
  logic tx_we, rx_we, flags_we, catch_we;

  assign sel_lock  = addr_i == ADDR_W'(OFF_LOCK);
  assign sel_ssr   = addr_i == ADDR_W'(OFF_SSR);
  assign sel_tx    = addr_i == ADDR_W'(OFF_TX);
  assign sel_rx    = addr_i == ADDR_W'(OFF_RX);
  assign sel_flags = addr_i == ADDR_W'(OFF_FLAGS);
  assign sel_catch = addr_i == ADDR_W'(OFF_CATCH);

  assign lock_wr  = we_i && sel_lock;
  assign ssr_acc  = (we_i || re_i) && sel_ssr;
  assign ssr_live = locked && ptr != '0 && ptr <= LAST;

  // restore writes share the direct-write strobes
  assign tx_we    = we_i && (sel_tx    || (sel_ssr && ssr_live && ptr == PTR_W'(1)));
  assign rx_we    = we_i && (sel_rx    || (sel_ssr && ssr_live && ptr == PTR_W'(2)));
  assign flags_we = we_i && (sel_flags || (sel_ssr && ssr_live && ptr == PTR_W'(3)));
  assign catch_we = we_i && (sel_catch || (sel_ssr && ssr_live && ptr == PTR_W'(4)));

  dbg_lock_ctrl u_lock (
    .clk_i, .rst_ni,
    .lock_wr_i (lock_wr),
    .wdata_i,
    .catch_en_i(catch_en),
    .locked_o  (locked),
    .event_o
  );

  dbg_seq_ptr #(.NUM_WORDS(NUM_WORDS), .PTR_W(PTR_W)) u_ptr (
    .clk_i, .rst_ni,
    .lock_wr_i(lock_wr),
    .ssr_acc_i(ssr_acc),
    .locked_i (locked),
    .ptr_o    (ptr)
  );

  dbg_state_regs u_regs (
    .clk_i, .rst_ni,
    .tx_we_i   (tx_we),
    .rx_we_i   (rx_we),
    .flags_we_i(flags_we),
    .catch_we_i(catch_we),
    .wdata_i,
    .tx_o      (tx),
    .rx_o      (rx),
    .flags_o   (flags),
    .catch_o   (catch_en)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_lock)       rdata_o = {31'b0, locked};
    else if (sel_tx)    rdata_o = tx;
    else if (sel_rx)    rdata_o = rx;
    else if (sel_flags) rdata_o = {28'b0, flags};
    else if (sel_catch) rdata_o = {31'b0, catch_en};
    else if (sel_ssr && locked) begin
      if (ptr == '0) rdata_o = 32'(NUM_WORDS);
      else if (ptr <= LAST) begin
        case (ptr)
          PTR_W'(1): rdata_o = tx;
          PTR_W'(2): rdata_o = rx;
          PTR_W'(3): rdata_o = {28'b0, flags};
          PTR_W'(4): rdata_o = {31'b0, catch_en};
          default:   rdata_o = '0;
        endcase
      end
    end
  end

  a_r9_unlocked_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ssr && !locked) |-> (rdata_o == '0));
  a_r4_count_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked) |-> (ptr == '0));
endmodule

// File: tb/dbg_state_port_bench.sv
module dbg_state_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 6;
  localparam logic [31:0] KEY = 32'hC5AC_CE55;

  logic clk_i = 0, rst_ni = 0, we_i = 0, re_i = 0, event_o;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;

  int checks = 0, failures = 0;
  bit done = 0;

  bit m_lock = 0, m_catch = 0, m_ev = 0;
  int m_ptr = 0;
  logic [31:0] m_tx = 0, m_rx = 0;
  logic [3:0]  m_flags = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dbg_state_port #(.ADDR_W(12), .NUM_WORDS(NW)) u_dbg_state_port (
    .clk_i, .rst_ni, .addr_i, .we_i, .re_i, .wdata_i, .rdata_o, .event_o);

  function automatic logic [31:0] word_at(int i);
    case (i)
      1: return m_tx;
      2: return m_rx;
      3: return {28'b0, m_flags};
      4: return {31'b0, m_catch};
      default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    case (a)
      12'h300: return {31'b0, m_lock};
      12'h080: return m_tx;
      12'h084: return m_rx;
      12'h088: return {28'b0, m_flags};
      12'h0A0: return {31'b0, m_catch};
      12'h308: begin
        if (!m_lock || m_ptr > NW) return '0;
        if (m_ptr == 0) return NW;
        return word_at(m_ptr);
      end
      default: return '0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_wr(logic [11:0] a, logic [31:0] d);
    case (a)
      12'h300: begin
        m_ev = m_lock && (d != KEY) && m_catch;
        m_lock = (d == KEY);
        m_ptr = 0;
      end
      12'h080: m_tx = d;
      12'h084: m_rx = d;
      12'h088: m_flags = d[3:0];
      12'h0A0: m_catch = d[0];
      12'h308: if (m_lock && m_ptr <= NW) begin
        case (m_ptr)
          1: m_tx = d;
          2: m_rx = d;
          3: m_flags = d[3:0];
          4: m_catch = d[0];
          default: ;
        endcase
        m_ptr++;
      end
      default: ;
    endcase
  endtask

  task automatic acc(bit w, logic [11:0] a, logic [31:0] d, string req);
    @(negedge clk_i);
    we_i = w; re_i = !w; addr_i = a; wdata_i = d;
    #1;
    if (!w) begin
      check(req, rdata_o, exp_rd(a));
      if (a == 12'h308 && m_lock && m_ptr <= NW) m_ptr++;
    end else model_wr(a, d);
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 0; re_i = 0;
    check({req, " R8 event"}, {31'b0, event_o}, {31'b0, m_ev});
    m_ev = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    check("R1 event", {31'b0, event_o}, 0);
    acc(0, 12'h300, 0, "R1 lock");
    acc(0, 12'h080, 0, "R1 tx");
    acc(0, 12'h088, 0, "R1 flags");
    acc(0, 12'h0A0, 0, "R1 catch");
    // R9 unlocked port
    acc(1, 12'h308, 32'h1234, "R9 write");
    acc(0, 12'h308, 0, "R9 read");
    acc(0, 12'h080, 0, "R9 tx untouched");
    // R11 direct regs
    acc(1, 12'h080, 32'hAAAA_0001, "R11 tx");
    acc(1, 12'h084, 32'hBBBB_0002, "R11 rx");
    acc(1, 12'h088, 32'hFFFF_FFF5, "R11 flags");
    acc(1, 12'h0A0, 32'h1, "R11 catch");
    acc(0, 12'h088, 0, "R11 flags rd");
    // R2 R4 R5 save
    acc(1, 12'h300, KEY, "R2 lock");
    acc(0, 12'h300, 0, "R2 lock rd");
    acc(0, 12'h308, 0, "R4 count");
    for (int i = 1; i <= NW; i++) acc(0, 12'h308, 0, "R5 word");
    acc(0, 12'h308, 0, "R10 overrun");
    acc(1, 12'h308, 32'hDEAD, "R10 overrun wr");
    acc(0, 12'h080, 0, "R10 tx kept");
    // R7 rewind then R6 restore
    acc(1, 12'h300, KEY, "R7 rewind");
    acc(0, 12'h308, 0, "R7 count again");
    acc(1, 12'h300, KEY, "R7 rewind2");
    acc(1, 12'h308, 32'h0, "R6 count");
    acc(1, 12'h308, 32'h1111_2222, "R6 tx");
    acc(1, 12'h308, 32'h3333_4444, "R6 rx");
    acc(1, 12'h308, 32'hA, "R6 flags");
    acc(1, 12'h308, 32'h1, "R6 catch");
    acc(0, 12'h080, 0, "R6 tx rd");
    acc(0, 12'h084, 0, "R6 rx rd");
    acc(0, 12'h088, 0, "R6 flags rd");
    // R3 R8 unlock with catch
    acc(1, 12'h300, 32'h0, "R3 R8 unlock");
    acc(0, 12'h300, 0, "R3 lock rd");
    acc(1, 12'h300, 32'h0, "R8 already clear");
    acc(1, 12'h0A0, 32'h0, "R8 catch off");
    acc(1, 12'h300, KEY, "R8 lock");
    acc(1, 12'h300, 32'h5, "R8 unlock no catch");
    // random mix
    for (int n = 0; n < 600; n++) begin
      int r = $urandom % 10;
      logic [31:0] d = $urandom;
      case (r)
        0: acc(1, 12'h300, KEY, "R2 rnd");
        1: acc(1, 12'h300, d, "R3 rnd");
        2, 3, 4: acc(0, 12'h308, 0, "R5 rnd");
        5, 6: acc(1, 12'h308, d, "R6 rnd");
        7: acc(1, (d[0] ? 12'h080 : 12'h088), d, "R11 rnd");
        8: acc(0, (d[1] ? 12'h084 : 12'h0A0), 0, "R11 rnd rd");
        default: acc(1, 12'h0A0, d, "R8 rnd");
      endcase
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule